// File: doc/BRIEF.md
# Mode-Selectable Signed/Unsigned Multiplier

This block multiplies a 16-bit multiplier-register value by a 16-bit multiplicand. Before the multiply, the multiplier-register operand is widened to 17 bits. An input mode flag decides how that extra top bit is filled. When the flag requests unsigned treatment, the extra bit is zero. Otherwise the extra bit copies bit 15 of the operand, so the operand is read as two's complement. The multiplicand is always sign-extended to 17 bits.

The 34-bit product is cut down to its lower 32 bits and split into two words. The low word is meant for the destination accumulator and the high word for a separate product-high register. A start strobe launches the operation. On the next clock edge both words are registered and a one-cycle done pulse is raised. The mode flag is an input only; the block does not store it.

Top module: `mode_mul`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_lo` and `prod_hi` become 0x0000 and `done` becomes 0.
- R2: With `uns_mode`=1, the multiplier operand `mr_in` is treated as unsigned: its 17th bit is 0. For example, 0x8000 × 0x0080 gives `prod_hi`=0x0040 and `acc_lo`=0x0000.
- R3: With `uns_mode`=0, bit 15 of `mr_in` is copied into the 17th bit, giving signed behaviour. For example, 0x8000 × 0x0080 gives `prod_hi`=0xFFC0 and `acc_lo`=0x0000.
- R4: The multiplicand `mcand_in` is always sign-extended from bit 15, whatever the value of `uns_mode`.
- R5: `acc_lo` holds bits 15:0 of the product and `prod_hi` holds bits 31:16. Product bits 33:32 are discarded.
- R6: The result words update on the first clock edge after an edge where `start` is sampled high, and `done` is high for exactly that one cycle.
- R7: When `start` is low at an edge, `acc_lo` and `prod_hi` keep their values and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a multiply |
| uns_mode | input | 1 | 1 = multiplier operand unsigned, 0 = signed |
| mr_in | input | 16 | Multiplier-register operand |
| mcand_in | input | 16 | Multiplicand |
| acc_lo | output | 16 | Low product word |
| prod_hi | output | 16 | High product word |
| done | output | 1 | Result valid pulse |

## Verification
The checker assumes that `start`, `uns_mode`, `mr_in` and `mcand_in` are stable across each sampling edge. The bench drives them only at falling edges. The assertions compare registered results against the operands sampled one edge earlier, so they take for granted that the operands are known (not X) whenever `start` is high. The stimulus assigns every operand before it raises `start`, and holds `start` low during reset.

// File: rtl/mode_mul_pkg.sv
package mode_mul_pkg;
   typedef enum logic {MR_SIGNED = 1'b0, MR_UNSIGNED = 1'b1} mr_mode_e;
endpackage

// File: rtl/mode_mul_ext.sv
module mode_mul_ext #(
   parameter int W = 16,
   parameter bit FORCE_SIGNED = 1'b0
) (
   input  logic [W-1:0] val,
   input  logic         uns,
   output logic [W:0]   ext
);
   generate
      if (FORCE_SIGNED) begin : g_sx
         assign ext = {val[W-1], val};
      end else begin : g_mode
         assign ext = {(uns ? 1'b0 : val[W-1]), val};
      end
   endgenerate
endmodule

// File: rtl/mode_mul_core.sv
module mode_mul_core #(
   parameter int W = 16,
   localparam int EW = W + 1,
   localparam int PW = 2 * EW
) (
   input  logic [EW-1:0] a,
   input  logic [EW-1:0] b,
   output logic [2*W-1:0] prod
);
   logic signed [PW-1:0] full;
   always_comb full = $signed(a) * $signed(b);
   assign prod = full[2*W-1:0];
endmodule

// File: rtl/mode_mul.sv
module mode_mul #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         uns_mode,
   input  logic [15:0]  mr_in,
   input  logic [15:0]  mcand_in,
   output logic [15:0]  acc_lo,
   output logic [15:0]  prod_hi,
   output logic         done
);
   import mode_mul_pkg::*;
   initial begin
      if (W != 16) $error("mode_mul: W must be 16 to match port widths");
   end

   mr_mode_e  mode;
   logic [W:0] mr_x, mc_x;
   logic [2*W-1:0] prod;

   assign mode = mr_mode_e'(uns_mode);

   mode_mul_ext #(.W(W), .FORCE_SIGNED(1'b0)) u_mr_ext (
      .val(mr_in), .uns(mode == MR_UNSIGNED), .ext(mr_x));
   mode_mul_ext #(.W(W), .FORCE_SIGNED(1'b1)) u_mc_ext (
      .val(mcand_in), .uns(1'b0), .ext(mc_x));
   mode_mul_core #(.W(W)) u_core (.a(mr_x), .b(mc_x), .prod(prod));

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_lo  <= '0;
         prod_hi <= '0;
         done    <= 1'b0;
      end else begin
         done <= start;
         if (start) begin
            acc_lo  <= prod[W-1:0];
            prod_hi <= prod[2*W-1:W];
         end
      end
   end
endmodule

// File: rtl/mode_mul_chk.sv
module mode_mul_chk (
   input logic        clk,
   input logic        rst,
   input logic        start,
   input logic        uns_mode,
   input logic [15:0] mr_in,
   input logic [15:0] mcand_in,
   input logic [15:0] acc_lo,
   input logic [15:0] prod_hi,
   input logic        done
);
   logic signed [33:0] ref_p;
   always_comb ref_p = $signed({(uns_mode ? 1'b0 : mr_in[15]), mr_in})
                     * $signed({mcand_in[15], mcand_in});

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (acc_lo == 16'h0 && prod_hi == 16'h0 && !done));
   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> done);
   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !start |=> (!done && $stable(acc_lo) && $stable(prod_hi)));
   // R5
   result_value_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> ({prod_hi, acc_lo} == $past(ref_p[31:0])));
endmodule

bind mode_mul mode_mul_chk u_chk (.*);

// File: tb/mode_mul_bench.sv
module mode_mul_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;
   // {uns, mr, mcand, expected product}
   localparam logic [64:0] VEC [NV] = '{
      {1'b1, 16'h8000, 16'h0080, 32'h0040_0000},  // R2
      {1'b0, 16'h8000, 16'h0080, 32'hFFC0_0000},  // R3
      {1'b1, 16'hFFFF, 16'hFFFF, 32'hFFFF_0001},  // R4 mcand -1, mr 65535
      {1'b0, 16'hFFFF, 16'hFFFF, 32'h0000_0001},
      {1'b1, 16'h8000, 16'h8000, 32'hC000_0000},  // R4 mcand negative
      {1'b0, 16'h8000, 16'h8000, 32'h4000_0000},
      {1'b1, 16'hFFFF, 16'h7FFF, 32'h7FFE_8001},  // R5
      {1'b0, 16'h1234, 16'h0010, 32'h0001_2340}
   };

   logic clk = 0, rst = 1, start = 0, uns_mode = 0;
   logic [15:0] mr_in = 0, mcand_in = 0;
   logic [15:0] acc_lo, prod_hi;
   logic done;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mode_mul u_mode_mul (.*);

   task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run(input logic u, input logic [15:0] a, input logic [15:0] b);
      @(negedge clk);
      uns_mode = u; mr_in = a; mcand_in = b; start = 1;
      @(negedge clk);
      start = 0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 5000);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset", {done, prod_hi, acc_lo}, 33'h0);
      rst = 0;
      for (int i = 0; i < NV; i++) begin
         run(VEC[i][64], VEC[i][63:48], VEC[i][47:32]);
         chk("R5 R6 vector", {done, prod_hi, acc_lo}, {1'b1, VEC[i][31:0]});
      end
      // R7: idle cycle holds value, done low
      @(negedge clk);
      chk("R7 hold", {done, prod_hi, acc_lo}, {1'b0, 32'h0001_2340});
      // R7: operands change without start
      uns_mode = 1; mr_in = 16'hFFFF; mcand_in = 16'hFFFF;
      @(negedge clk);
      chk("R7 ignore", {done, prod_hi, acc_lo}, {1'b0, 32'h0001_2340});
      // R2 split words
      run(1'b1, 16'h8000, 16'h0080);
      chk("R2 high word", {17'h0, prod_hi}, {17'h0, 16'h0040});
      run(1'b0, 16'h8000, 16'h0080);
      chk("R3 high word", {17'h0, prod_hi}, {17'h0, 16'hFFC0});
      // R6 back-to-back starts
      @(negedge clk);
      uns_mode = 0; mr_in = 16'h0002; mcand_in = 16'h0003; start = 1;
      @(negedge clk);
      chk("R6 first", {done, prod_hi, acc_lo}, {1'b1, 32'h6});
      mr_in = 16'h0004;
      @(negedge clk);
      start = 0;
      chk("R6 second", {done, prod_hi, acc_lo}, {1'b1, 32'hC});
      @(negedge clk);
      chk("R6 done drops", {32'h0, done}, 33'h0);
      // R1 reset clears nonzero result
      rst = 1;
      @(negedge clk);
      chk("R1 clear", {done, prod_hi, acc_lo}, 33'h0);
      rst = 0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule